// File: doc/BRIEF.md
# Character-Sync Hunt Detector

This block finds character alignment in a bit-serial receive stream for character-oriented synchronous links. Each receive bit arrives on `rx_bit`, qualified by a one-cycle `rx_en` strobe in the system clock domain. While the block is hunting, it looks for the point where character framing starts. Once that point is found, it raises a one-cycle `boundary` strobe and leaves the hunt state. A downstream character assembler starts counting bits at that strobe.

Four modes are available. The two internal modes compare the most recent received bits against a programmable pattern after every bit. They drive an active-low sync pulse on each match, at any bit offset. External mode takes alignment from an active-low sync input that outside logic asserts. In that mode the block reports how many bits of the first character already arrived before the input was seen. In asynchronous mode the sync input is only a status level.

Top module: `synchunt_detector`

## Requirements
- R1: After reset, `hunting` is 1, `sync_out_n` is 1, `boundary` is 0 and `bnd_fill` is 0.
- R2: `mode` is encoded as follows: 0 is asynchronous, 1 is monosync, 2 is bisync and 3 is external. `sync_oe` is 1 exactly in modes 1 and 2.
- R3: In monosync mode, a match occurs on an `rx_en` cycle when the last 8 received bits equal `pattern[7:0]`, with the earliest of the 8 bits compared against bit 7. At least 8 bits must have been received since reset. After a match, `sync_out_n` is 0 from the next cycle until the next `rx_en` cycle.
- R4: In bisync mode, the match uses the last 16 received bits against `pattern[15:0]`. The earliest received bit is compared against bit 15, so `pattern[15:8]` is the byte received first. At least 16 bits must have been received since reset. The sync pulse is the same as in R3.
- R5: Matching is tested after every received bit, not only on character boundaries. Overlapping or back-to-back matches each hold `sync_out_n` low for their own bit time.
- R6: When an internal-mode match occurs while hunting, the next cycle shows `hunting` 0, `boundary` 1 for exactly one cycle, and `bnd_fill` 0. A match while not hunting still pulses `sync_out_n` but gives no `boundary`.
- R7: `hunt_cmd` sets `hunting` on the next cycle and suppresses any boundary from the same cycle, even when a match coincides with it.
- R8: In external mode, the first cycle in which `sync_in_n` is sampled 0 after being 1, while hunting, leads to `boundary` 1 and `hunting` 0 on the next cycle. At that point `bnd_fill` is 1 plus the value of `rx_en` in the detection cycle. This is the number of bits already received, counted from the receive edge just before the input became active.
- R9: In external mode, an active or falling `sync_in_n` while not hunting produces no `boundary`.
- R10: In asynchronous mode, `sync_in_n` never changes `hunting` or `boundary`. `sync_stat` equals the inverse of `sync_in_n` one cycle later, in both asynchronous and external modes. In internal modes, `sync_stat` equals `hunting`.
- R11: On cycles with `rx_en` 0, `rx_bit` is ignored and `sync_out_n` holds its value.
- R12: In asynchronous and external modes, `sync_out_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Mode select: 0 asynchronous, 1 monosync, 2 bisync, 3 external |
| pattern | input | 16 | Sync pattern; monosync uses the low byte |
| rx_en | input | 1 | One-cycle receive bit strobe |
| rx_bit | input | 1 | Serial receive data, valid when `rx_en` is 1 |
| hunt_cmd | input | 1 | Re-enter the hunt state |
| sync_in_n | input | 1 | Active-low external sync or status input |
| sync_out_n | output | 1 | Active-low sync match pulse in internal modes |
| sync_oe | output | 1 | 1 when the sync line is driven as an output |
| hunting | output | 1 | Hunt state flag |
| boundary | output | 1 | One-cycle character boundary strobe |
| bnd_fill | output | 2 | Bits of the first character already received at `boundary` |
| sync_stat | output | 1 | Sync/hunt status level |

## Verification
The bench targets the following corner cases:
- Patterns that overlap themselves, such as alternating bits and all ones. A detector that only tests aligned positions, or that needs a rising edge of the match, would miss the second and later pulses.
- The fill guard after reset, using an all-zero pattern fed with zero bits. A detector without the guard would pulse before 8 or 16 bits have arrived.
- A hunt command in the same cycle as a match. A design with the wrong priority would emit a boundary and drop the hunt.
- External sync activation both on a receive-strobe cycle and between strobes. A design that does not back-date the boundary would report the wrong fill count.

// File: rtl/synchunt_pkg.sv
package synchunt_pkg;

    typedef enum logic [1:0] {
        SM_ASYNC = 2'd0,
        SM_MONO  = 2'd1,
        SM_BI    = 2'd2,
        SM_EXT   = 2'd3
    } sync_mode_e;

    localparam int FILL_W = 2;

    // boundary event produced by the external-sync edge logic
    typedef struct packed {
        logic              valid;
        logic [FILL_W-1:0] fill;
    } bnd_evt_t;

    // modes in which the sync line is an output and the pattern is compared
    function automatic logic is_internal(input sync_mode_e m);
        return (m == SM_MONO) || (m == SM_BI);
    endfunction

    // bits that must have arrived before a compare is trusted
    function automatic int need_bits(input sync_mode_e m, input int pat_w);
        return (m == SM_MONO) ? pat_w / 2 : pat_w;
    endfunction

endpackage

// File: rtl/synchunt_shift.sv
module synchunt_shift
    import synchunt_pkg::*;
#(
    parameter int PAT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  sync_mode_e       mode,
    input  logic [PAT_W-1:0] pattern,
    input  logic             rx_en,
    input  logic             rx_bit,
    output logic             match_now,
    output logic             sync_out_n
);
    localparam int BYTE_W = PAT_W / 2;
    localparam int CNT_W  = $clog2(PAT_W + 1);

    logic [PAT_W-1:0] sr_q;
    logic [PAT_W-1:0] sr_next;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] need;
    logic             hit;
    logic             internal;
    logic             sync_q;

    assign internal = is_internal(mode);
    assign sr_next  = {sr_q[PAT_W-2:0], rx_bit};
    assign cnt_next = (cnt_q == CNT_W'(PAT_W)) ? cnt_q : cnt_q + 1'b1;
    assign need     = CNT_W'(need_bits(mode, PAT_W));

    // width of the compare is picked by the mode; both compares are built
    logic [1:0] cmp_hit;
    generate
        for (genvar g = 0; g < 2; g++) begin : g_cmp
            localparam int W = (g == 0) ? BYTE_W : PAT_W;
            assign cmp_hit[g] = (sr_next[W-1:0] == pattern[W-1:0]);
        end
    endgenerate

    assign hit       = (mode == SM_MONO) ? cmp_hit[0] : cmp_hit[1];
    assign match_now = rx_en && internal && (cnt_next >= need) && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            sync_q <= 1'b1;
        end else begin
            if (rx_en) begin
                sr_q  <= sr_next;
                cnt_q <= cnt_next;
            end
            if (!internal) begin
                sync_q <= 1'b1;
            end else if (rx_en) begin
                sync_q <= !match_now;
            end
        end
    end

    assign sync_out_n = sync_q;

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && internal) |=> ($stable(sr_q) && $stable(sync_out_n)));

    assert_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !internal |=> sync_out_n);

    assert_fill_guard_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q < CNT_W'(BYTE_W - 1)) |=> sync_out_n);

endmodule

// File: rtl/synchunt_edge.sv
module synchunt_edge
    import synchunt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sync_mode_e mode,
    input  logic       rx_en,
    input  logic       sync_in_n,
    output bnd_evt_t   ext_evt,
    output logic       stat_q
);
    logic prev_n_q;

    // activation seen this cycle; the receive edge before it counts as bit one
    always_comb begin
        ext_evt.valid = (mode == SM_EXT) && !sync_in_n && prev_n_q;
        ext_evt.fill  = rx_en ? FILL_W'(2) : FILL_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n_q <= 1'b1;
            stat_q   <= 1'b0;
        end else begin
            prev_n_q <= sync_in_n;
            stat_q   <= !sync_in_n;
        end
    end

    assert_edge_once_R9: assert property (@(posedge clk) disable iff (rst)
        ext_evt.valid |=> !ext_evt.valid);

endmodule

// File: rtl/synchunt_hunt.sv
module synchunt_hunt
    import synchunt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hunt_cmd,
    input  logic              int_match,
    input  bnd_evt_t          ext_evt,
    output logic              hunting,
    output logic              boundary,
    output logic [FILL_W-1:0] bnd_fill
);
    logic              hunt_q;
    bnd_evt_t          bnd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hunt_q <= 1'b1;
            bnd_q  <= '0;
        end else begin
            bnd_q <= '0;
            if (hunt_cmd) begin
                hunt_q <= 1'b1;
            end else if (hunt_q && (int_match || ext_evt.valid)) begin
                hunt_q      <= 1'b0;
                bnd_q.valid <= 1'b1;
                bnd_q.fill  <= ext_evt.valid ? ext_evt.fill : '0;
            end
        end
    end

    assign hunting  = hunt_q;
    assign boundary = bnd_q.valid;
    assign bnd_fill = bnd_q.fill;

    assert_one_shot_R6: assert property (@(posedge clk) disable iff (rst)
        boundary |=> !boundary);

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        boundary |-> !hunting);

    assert_cmd_wins_R7: assert property (@(posedge clk) disable iff (rst)
        hunt_cmd |=> (hunting && !boundary));

    assert_ext_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (hunting && ext_evt.valid && !hunt_cmd) |=> (boundary && bnd_fill != '0));

    assert_int_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (hunting && int_match && !ext_evt.valid && !hunt_cmd) |=> (boundary && bnd_fill == '0));

endmodule

// File: rtl/synchunt_detector.sv
module synchunt_detector
    import synchunt_pkg::*;
#(
    parameter int PAT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic [PAT_W-1:0]  pattern,
    input  logic              rx_en,
    input  logic              rx_bit,
    input  logic              hunt_cmd,
    input  logic              sync_in_n,
    output logic              sync_out_n,
    output logic              sync_oe,
    output logic              hunting,
    output logic              boundary,
    output logic [FILL_W-1:0] bnd_fill,
    output logic              sync_stat
);
    sync_mode_e mode_e;
    logic       int_match;
    bnd_evt_t   ext_evt;
    logic       stat_q;

    assign mode_e = sync_mode_e'(mode);

    synchunt_shift #(.PAT_W(PAT_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .pattern    (pattern),
        .rx_en      (rx_en),
        .rx_bit     (rx_bit),
        .match_now  (int_match),
        .sync_out_n (sync_out_n)
    );

    synchunt_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .rx_en     (rx_en),
        .sync_in_n (sync_in_n),
        .ext_evt   (ext_evt),
        .stat_q    (stat_q)
    );

    synchunt_hunt u_hunt (
        .clk       (clk),
        .rst       (rst),
        .hunt_cmd  (hunt_cmd),
        .int_match (int_match),
        .ext_evt   (ext_evt),
        .hunting   (hunting),
        .boundary  (boundary),
        .bnd_fill  (bnd_fill)
    );

    assign sync_oe   = is_internal(mode_e);
    assign sync_stat = sync_oe ? hunting : stat_q;

    assert_oe_R2: assert property (@(posedge clk) disable iff (rst)
        !sync_oe |-> sync_out_n || $past(sync_oe));

    assert_async_inert_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_e == SM_ASYNC && !hunt_cmd) |=> !boundary);

endmodule

// File: tb/test_synchunt_detector.sv
module test_synchunt_detector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd1;
    logic [15:0] pattern = 16'h0096;
    logic        rx_en = 1'b0;
    logic        rx_bit = 1'b0;
    logic        hunt_cmd = 1'b0;
    logic        sync_in_n = 1'b1;
    logic        sync_out_n, sync_oe, hunting, boundary, sync_stat;
    logic [1:0]  bnd_fill;

    synchunt_detector i_synchunt_detector (
        .clk(clk), .rst(rst), .mode(mode), .pattern(pattern), .rx_en(rx_en),
        .rx_bit(rx_bit), .hunt_cmd(hunt_cmd), .sync_in_n(sync_in_n),
        .sync_out_n(sync_out_n), .sync_oe(sync_oe), .hunting(hunting),
        .boundary(boundary), .bnd_fill(bnd_fill), .sync_stat(sync_stat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic       sync_n;
        logic       bnd;
        logic [1:0] fill;
        logic       hunt;
        logic       stat;
        logic       oe;
        string      tag;
    } exp_t;
    exp_t exq[$];

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R1";

    // reference state, derived from the requirements
    logic [31:0] m_hist;
    int          m_n;
    logic        m_sync_n, m_hunt, m_prev_sn, m_stat;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hist = '0; m_n = 0; m_sync_n = 1'b1; m_hunt = 1'b1; m_prev_sn = 1'b1; m_stat = 1'b0;
    endtask

    // driver: one cycle of stimulus plus its expected outcome
    task automatic step(input logic en, input logic b, input logic sn, input logic hc);
        exp_t e;
        logic internal, match, ext_ev, bnd;
        logic [1:0] fill;
        @(negedge clk);
        rx_en = en; rx_bit = b; sync_in_n = sn; hunt_cmd = hc;
        internal = (mode == 2'd1) || (mode == 2'd2);
        match = 1'b0;
        if (en) begin
            m_hist = {m_hist[30:0], b};
            m_n++;
            if (mode == 2'd1) match = (m_n >= 8) && (m_hist[7:0] == pattern[7:0]);
            if (mode == 2'd2) match = (m_n >= 16) && (m_hist[15:0] == pattern);
        end
        if (!internal) m_sync_n = 1'b1;
        else if (en) m_sync_n = !match;
        ext_ev = (mode == 2'd3) && !sn && m_prev_sn;
        bnd = 1'b0; fill = 2'd0;
        if (hc) m_hunt = 1'b1;
        else if (m_hunt && ((internal && match) || ext_ev)) begin
            m_hunt = 1'b0; bnd = 1'b1;
            fill = ext_ev ? (en ? 2'd2 : 2'd1) : 2'd0;
        end
        m_prev_sn = sn;
        m_stat = !sn;
        e.sync_n = m_sync_n; e.bnd = bnd; e.fill = fill; e.hunt = m_hunt;
        e.stat = internal ? m_hunt : m_stat; e.oe = internal; e.tag = cur_tag;
        exq.push_back(e);
    endtask

    // monitor: compares each registered result a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exq.size() > 0) begin
                exp_t e;
                e = exq.pop_front();
                chk(e.tag, "sync_out_n", sync_out_n, e.sync_n);
                chk(e.tag, "boundary", boundary, e.bnd);
                chk(e.tag, "bnd_fill", bnd_fill, e.fill);
                chk(e.tag, "hunting", hunting, e.hunt);
                chk(e.tag, "sync_stat", sync_stat, e.stat);
                chk(e.tag, "sync_oe", sync_oe, e.oe);
            end
        end
    end

    task automatic do_reset(input logic [1:0] m, input logic [15:0] p);
        @(negedge clk);
        rst = 1'b1; mode = m; pattern = p; rx_en = 0; hunt_cmd = 0; sync_in_n = 1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk("R1", "reset hunting", hunting, 1);
        chk("R1", "reset sync_out_n", sync_out_n, 1);
        chk("R1", "reset boundary", boundary, 0);
        chk("R1", "reset bnd_fill", bnd_fill, 0);
        chk("R2", "reset sync_oe", sync_oe, (m == 2'd1) || (m == 2'd2));
    endtask

    task automatic send_bits(input logic [15:0] v, input int nb, input int gap);
        for (int i = nb - 1; i >= 0; i--) begin
            step(1'b1, v[i], 1'b1, 1'b0);
            for (int k = 0; k < gap; k++) step(1'b0, ~v[i], 1'b1, 1'b0);
        end
    endtask

    task automatic noise(input int n);
        for (int i = 0; i < n; i++) step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1'b1, 1'b0);
    endtask

    initial begin
        model_reset();
        // monosync basic, with idle gaps between bits
        do_reset(2'd1, 16'h0096);
        cur_tag = "R3"; send_bits(16'h0003, 3, 0); send_bits(16'h0096, 8, 0);
        cur_tag = "R6"; send_bits(16'h0096, 8, 0);
        cur_tag = "R11"; send_bits(16'h0096, 8, 2);
        cur_tag = "R3"; noise(200);
        // fill guard with an all-zero pattern
        do_reset(2'd1, 16'h0000);
        cur_tag = "R3"; send_bits(16'h0000, 12, 1);
        // overlapping matches
        do_reset(2'd1, 16'h00AA);
        cur_tag = "R5"; send_bits(16'hAAAA, 16, 0); send_bits(16'hAAAA, 16, 1);
        do_reset(2'd1, 16'h00FF);
        cur_tag = "R5"; send_bits(16'hFFFF, 14, 0);
        // hunt command collides with a match
        do_reset(2'd1, 16'h0096);
        cur_tag = "R7"; send_bits(16'h0096, 7, 0);
        step(1'b1, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        send_bits(16'h0096, 8, 0);
        step(1'b0, 1'b0, 1'b1, 1'b1);
        send_bits(16'h0096, 8, 0);
        // bisync
        do_reset(2'd2, 16'h1632);
        cur_tag = "R4"; send_bits(16'h0032, 8, 0); send_bits(16'h1632, 16, 0);
        send_bits(16'h3216, 16, 0); send_bits(16'h1632, 16, 1); noise(300);
        do_reset(2'd2, 16'h0000);
        cur_tag = "R4"; send_bits(16'h0000, 16, 0); send_bits(16'h0000, 3, 0);
        // external sync
        do_reset(2'd3, 16'h0096);
        cur_tag = "R12"; send_bits(16'h0096, 8, 0);
        cur_tag = "R8";
        step(1'b1, 1'b1, 1'b1, 1'b0); step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0); step(1'b0, 1'b1, 1'b1, 1'b0);
        cur_tag = "R9";
        step(1'b0, 1'b0, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b1, 1'b0);
        cur_tag = "R8";
        step(1'b0, 1'b0, 1'b1, 1'b1); step(1'b1, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0); step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0); step(1'b0, 1'b1, 1'b1, 1'b0);
        // asynchronous: sync input is status only
        do_reset(2'd0, 16'h0096);
        cur_tag = "R10";
        for (int i = 0; i < 40; i++) step(i % 3 == 0, 1'b1, (i % 5) < 2, 1'b0);
        send_bits(16'h0096, 8, 0);
        cur_tag = "R12"; noise(50);
        @(negedge clk); @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule